// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This block produces the second operand for a data-processing instruction of a 32-bit core, together with the shifter carry. It takes the instruction word, the two register values that have already been read (the value to be shifted and the value that holds a shift amount), and the current carry flag. From bit 25 and bit 4 of the word it selects one of three forms: an 8-bit immediate rotated by an even amount, a register shifted by a 5-bit constant, or a register shifted by an amount taken from the low byte of another register.

The combinational result is captured into output registers on each cycle where `in_valid` is high, and `out_valid` goes high for the following cycle. A two-state machine tracks whether the output registers hold a fresh result. `ST_IDLE` means that no result was captured on the last edge, and `ST_OUT` means that one was. The transition `capture` enters or stays in `ST_OUT` whenever `in_valid` is high. The transition `drain` goes to `ST_IDLE` whenever `in_valid` is low. The registered outputs keep their values in `ST_IDLE`.

The block also reports which operation it applied. The shift-type code `shift_kind` separates the rotate-through-carry case and the rotated-immediate case from the four ordinary shifts.

Top module: `opnd_shifter`

## Requirements
- R1: Reset (active low, asynchronous) clears `operand`, `carry_out`, `shift_kind` and `out_valid`. When `in_valid` is high at a rising edge, the outputs hold the result of that cycle's inputs after the edge and `out_valid` is 1. When `in_valid` is low, `out_valid` becomes 0 and the other outputs keep their values.
- R2: When instr[25]=1, the operand is instr[7:0] zero-extended and rotated right by 2*instr[11:8]. Examples: imm 0x3F with rotate 0xE gives 0x3F0, imm 0xFC with rotate 0xF gives 0x3F0, and low bits 0x101 give 0x40000000.
- R3: In the rotated-immediate form, carry-out equals carry-in when instr[11:8]=0 and otherwise equals bit 31 of the operand. The operand value never depends on carry-in.
- R4: When instr[25]=0 and instr[4]=0, `rm_val` is shifted by instr[11:7], with the type taken from instr[6:5]: 00 LSL, 01 LSR, 10 ASR, 11 ROR. For a nonzero amount, the carry-out is the last bit shifted out. Examples at 31: LSR of 0x80000000 gives 1, ASR of 0x80000000 gives 0xFFFFFFFF, ROR of 1 gives 2.
- R5: An immediate LSL by 0 passes `rm_val` through unchanged, and carry-out equals carry-in.
- R6: An immediate LSR or ASR with an amount field of 0 acts as a shift by 32. LSR gives 0 and ASR gives 32 copies of bit 31. In both cases the carry-out is `rm_val` bit 31.
- R7: An immediate ROR with an amount field of 0 is a rotate right through carry. The operand is {carry_in, rm_val[31:1]} and the carry-out is rm_val[0].
- R8: When instr[25]=0 and instr[4]=1, the amount is `rs_val[7:0]` and the upper bits of `rs_val` are ignored. For amounts 1 to 31, the shifts act as in R4. Examples: LSL 1 by 2 gives 4, LSR 2 by 1 gives 1, ASR 0x80000000 by 1 gives 0xC0000000.
- R9: For a register-specified shift, an amount of 0 passes `rm_val` through with carry-out equal to carry-in. LSL by 32 gives 0 with carry bit 0, and LSR by 32 gives 0 with carry bit 31. LSL or LSR by more than 32 gives 0 with carry 0. ASR by 32 or more gives copies of bit 31, with bit 31 as the carry.
- R10: A register-specified ROR uses the amount modulo 32. When the amount is nonzero but a multiple of 32, the operand is `rm_val` and the carry-out is bit 31.
- R11: `shift_kind` codes the operation applied: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry (immediate ROR #0 only), 5 rotated immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for this cycle's inputs |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register holding a shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is fresh this cycle |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |
| shift_kind | output | 3 | Registered operation code (R11) |

## Verification
The bench targets the zero-amount encodings, because each one means something different in each form. A design that treats an immediate LSR #0 as no shift returns `rm_val` where 0 is expected. A design that treats ROR #0 as a plain rotate drops carry-in from bit 31 and reports the wrong carry. The bench also covers register amounts of exactly 32, above 32, and with the low byte zero but upper bits set. A decoder that reads more than the low byte of `rs_val`, or that confuses the 32 case with the above-32 case, gives a wrong operand or carry there. Further checks cover the two immediate encodings that yield the same value and a rotate-zero immediate under both carry values. These expose a rotate amount that is not doubled and a carry that is taken from the wrong source.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_type_e;

    typedef enum logic [2:0] {
        K_LSL = 3'd0,
        K_LSR = 3'd1,
        K_ASR = 3'd2,
        K_ROR = 3'd3,
        K_RRX = 3'd4,
        K_IMM = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        F_IMM = 2'd0,
        F_ISH = 2'd1,
        F_RSH = 2'd2
    } form_e;

    typedef struct packed {
        form_e      form;
        sh_type_e   typ;
        logic [4:0] amt5;
        logic [7:0] imm8;
        logic [3:0] rot;
    } dec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } st_e;

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    always_comb begin
        if (instr[25])
            dec.form = F_IMM;
        else if (instr[4])
            dec.form = F_RSH;
        else
            dec.form = F_ISH;
        dec.typ  = sh_type_e'(instr[6:5]);
        dec.amt5 = instr[11:7];
        dec.imm8 = instr[7:0];
        dec.rot  = instr[11:8];
    end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
    import opsh_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] rm,
    input  logic [XLEN-1:0] rs,
    input  logic            cin,
    output logic [XLEN-1:0] res,
    output logic            cout,
    output kind_e           kind
);
    localparam int SHW = $clog2(XLEN);

    function automatic logic [XLEN-1:0] ror_f(logic [XLEN-1:0] v, int n);
        return (v >> n) | (v << (XLEN - n));
    endfunction

    function automatic logic [XLEN-1:0] asr_f(logic [XLEN-1:0] v, int n);
        return $signed(v) >>> n;
    endfunction

    logic [7:0]     a8;
    logic [SHW-1:0] a_low;
    int             ai;
    int             ri;

    always_comb begin
        res   = rm;
        cout  = cin;
        kind  = K_LSL;
        a8    = rs[7:0];
        a_low = rs[SHW-1:0];
        ai    = int'(dec.amt5);
        ri    = int'(a_low);
        unique case (dec.form)
            F_IMM: begin
                kind = K_IMM;
                res  = ror_f({{(XLEN-8){1'b0}}, dec.imm8}, int'({dec.rot, 1'b0}));
                cout = (dec.rot == 4'd0) ? cin : res[XLEN-1];
            end
            F_ISH: begin
                unique case (dec.typ)
                    SH_LSL: begin
                        kind = K_LSL;
                        if (ai != 0) begin
                            res  = rm << ai;
                            cout = rm[XLEN-ai];
                        end
                    end
                    SH_LSR: begin
                        kind = K_LSR;
                        if (ai == 0) begin
                            res  = '0;
                            cout = rm[XLEN-1];
                        end else begin
                            res  = rm >> ai;
                            cout = rm[ai-1];
                        end
                    end
                    SH_ASR: begin
                        kind = K_ASR;
                        if (ai == 0) begin
                            res  = {XLEN{rm[XLEN-1]}};
                            cout = rm[XLEN-1];
                        end else begin
                            res  = asr_f(rm, ai);
                            cout = rm[ai-1];
                        end
                    end
                    SH_ROR: begin
                        if (ai == 0) begin
                            kind = K_RRX;
                            res  = {cin, rm[XLEN-1:1]};
                            cout = rm[0];
                        end else begin
                            kind = K_ROR;
                            res  = ror_f(rm, ai);
                            cout = rm[ai-1];
                        end
                    end
                    default: ;
                endcase
            end
            F_RSH: begin
                unique case (dec.typ)
                    SH_LSL: begin
                        kind = K_LSL;
                        if (a8 == 8'd0) begin
                            res  = rm;
                            cout = cin;
                        end else if (int'(a8) < XLEN) begin
                            res  = rm << ri;
                            cout = rm[XLEN-ri];
                        end else if (int'(a8) == XLEN) begin
                            res  = '0;
                            cout = rm[0];
                        end else begin
                            res  = '0;
                            cout = 1'b0;
                        end
                    end
                    SH_LSR: begin
                        kind = K_LSR;
                        if (a8 == 8'd0) begin
                            res  = rm;
                            cout = cin;
                        end else if (int'(a8) < XLEN) begin
                            res  = rm >> ri;
                            cout = rm[ri-1];
                        end else if (int'(a8) == XLEN) begin
                            res  = '0;
                            cout = rm[XLEN-1];
                        end else begin
                            res  = '0;
                            cout = 1'b0;
                        end
                    end
                    SH_ASR: begin
                        kind = K_ASR;
                        if (a8 == 8'd0) begin
                            res  = rm;
                            cout = cin;
                        end else if (int'(a8) < XLEN) begin
                            res  = asr_f(rm, ri);
                            cout = rm[ri-1];
                        end else begin
                            res  = {XLEN{rm[XLEN-1]}};
                            cout = rm[XLEN-1];
                        end
                    end
                    SH_ROR: begin
                        kind = K_ROR;
                        if (a8 == 8'd0) begin
                            res  = rm;
                            cout = cin;
                        end else if (ri == 0) begin
                            res  = rm;
                            cout = rm[XLEN-1];
                        end else begin
                            res  = ror_f(rm, ri);
                            cout = rm[ri-1];
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opsh_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rm_val,
    input  logic [XLEN-1:0] rs_val,
    input  logic            carry_in,
    output logic            out_valid,
    output logic [XLEN-1:0] operand,
    output logic            carry_out,
    output logic [2:0]      shift_kind
);
    dec_t            dec;
    logic [XLEN-1:0] nxt_res;
    logic            nxt_cout;
    kind_e           nxt_kind;
    st_e             state_q;
    st_e             state_d;

    opsh_decode #(.XLEN(XLEN)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    opsh_barrel #(.XLEN(XLEN)) u_bar (
        .dec   (dec),
        .rm    (rm_val),
        .rs    (rs_val),
        .cin   (carry_in),
        .res   (nxt_res),
        .cout  (nxt_cout),
        .kind  (nxt_kind)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            operand    <= '0;
            carry_out  <= 1'b0;
            shift_kind <= 3'd0;
        end else if (in_valid) begin
            operand    <= nxt_res;
            carry_out  <= nxt_cout;
            shift_kind <= nxt_kind;
        end
    end

    assign out_valid = (state_q == ST_OUT);

    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));
    a_r3_norot_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[25] && instr[11:8] == 4'd0) |=>
        (carry_out == $past(carry_in) && operand == {{(XLEN-8){1'b0}}, $past(instr[7:0])}));
    a_r6_lsr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[25] && !instr[4] && instr[6:5] == 2'b01 && instr[11:7] == 5'd0) |=>
        (operand == '0 && carry_out == $past(rm_val[XLEN-1])));
    a_r7_rrx: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[25] && !instr[4] && instr[6:5] == 2'b11 && instr[11:7] == 5'd0) |=>
        (operand == {$past(carry_in), $past(rm_val[XLEN-1:1])} && carry_out == $past(rm_val[0])
         && shift_kind == 3'd4));
    a_r9_rs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[25] && instr[4] && rs_val[7:0] == 8'd0) |=>
        (operand == $past(rm_val) && carry_out == $past(carry_in)));
    a_r11_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (shift_kind <= 3'd5));
endmodule

// File: tb/tb_opnd_shifter.sv
`timescale 1ns/1ps
module tb_opnd_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;
    logic [2:0]  shift_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    opnd_shifter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in),
        .out_valid(out_valid), .operand(operand), .carry_out(carry_out),
        .shift_kind(shift_kind)
    );

    function automatic logic [31:0] f_imm(logic [3:0] rot, logic [7:0] v);
        return 32'h0200_0000 | (32'(rot) << 8) | 32'(v);
    endfunction
    function automatic logic [31:0] f_ish(logic [4:0] amt, logic [1:0] t);
        return (32'(amt) << 7) | (32'(t) << 5) | 32'h6;
    endfunction
    function automatic logic [31:0] f_rsh(logic [1:0] t);
        return (32'h6 << 8) | (32'(t) << 5) | 32'h10 | 32'h4;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic run(logic [31:0] i, logic [31:0] m, logic [31:0] s, logic c);
        @(negedge clk);
        instr = i; rm_val = m; rs_val = s; carry_in = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic vec(string tag, logic [31:0] i, logic [31:0] m, logic [31:0] s, logic c,
                       logic [31:0] e_op, logic e_c, logic [2:0] e_k);
        run(i, m, s, c);
        chk({tag, " operand"}, operand, e_op);
        chk({tag, " carry"}, 32'(carry_out), 32'(e_c));
        chk({tag, " kind"}, 32'(shift_kind), 32'(e_k));
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 reset operand", operand, 32'h0);
        chk("R1 reset carry", 32'(carry_out), 32'h0);
        chk("R1 reset valid", 32'(out_valid), 32'h0);
    endtask

    task automatic t_rot_imm;
        vec("R2 3F rot E", f_imm(4'hE, 8'h3F), 32'h0, 32'h0, 1'b0, 32'h3F0, 1'b0, 3'd5);
        vec("R2 FC rot F", f_imm(4'hF, 8'hFC), 32'h0, 32'h0, 1'b1, 32'h3F0, 1'b0, 3'd5);
        vec("R2 101", f_imm(4'h1, 8'h01), 32'h0, 32'h0, 1'b1, 32'h4000_0000, 1'b0, 3'd5);
        vec("R3 rot0 c1", f_imm(4'h0, 8'hFF), 32'h0, 32'h0, 1'b1, 32'hFF, 1'b1, 3'd5);
        vec("R3 rot0 c0", f_imm(4'h0, 8'hFF), 32'h0, 32'h0, 1'b0, 32'hFF, 1'b0, 3'd5);
        vec("R3 bit31 carry", f_imm(4'h1, 8'h02), 32'h0, 32'h0, 1'b0, 32'h8000_0000, 1'b1, 3'd5);
    endtask

    task automatic t_imm_shift;
        vec("R4 LSR31", f_ish(5'd31, 2'b01), 32'h8000_0000, 32'h0, 1'b0, 32'h1, 1'b0, 3'd1);
        vec("R4 ASR31", f_ish(5'd31, 2'b10), 32'h8000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 3'd2);
        vec("R4 ROR31", f_ish(5'd31, 2'b11), 32'h1, 32'h0, 1'b0, 32'h2, 1'b0, 3'd3);
        vec("R4 LSL4", f_ish(5'd4, 2'b00), 32'h1000_000F, 32'h0, 1'b0, 32'hF0, 1'b1, 3'd0);
        vec("R5 LSL0", f_ish(5'd0, 2'b00), 32'h1234_5678, 32'h0, 1'b1, 32'h1234_5678, 1'b1, 3'd0);
        vec("R6 LSR0", f_ish(5'd0, 2'b01), 32'h8000_0001, 32'h0, 1'b0, 32'h0, 1'b1, 3'd1);
        vec("R6 ASR0 neg", f_ish(5'd0, 2'b10), 32'h8000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1, 3'd2);
        vec("R6 ASR0 pos", f_ish(5'd0, 2'b10), 32'h7FFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b0, 3'd2);
    endtask

    task automatic t_rrx;
        vec("R7 rrx c1", f_ish(5'd0, 2'b11), 32'h0, 32'h0, 1'b1, 32'h8000_0000, 1'b0, 3'd4);
        vec("R7 rrx c0", f_ish(5'd0, 2'b11), 32'h8000_0000, 32'h0, 1'b0, 32'h4000_0000, 1'b0, 3'd4);
        vec("R7 rrx out", f_ish(5'd0, 2'b11), 32'h1, 32'h0, 1'b0, 32'h0, 1'b1, 3'd4);
    endtask

    task automatic t_reg_shift;
        vec("R8 LSL by2", f_rsh(2'b00), 32'h1, 32'h2, 1'b0, 32'h4, 1'b0, 3'd0);
        vec("R8 LSR by1", f_rsh(2'b01), 32'h2, 32'h1, 1'b1, 32'h1, 1'b0, 3'd1);
        vec("R8 ASR by1", f_rsh(2'b10), 32'h2, 32'h1, 1'b1, 32'h1, 1'b0, 3'd2);
        vec("R8 ASR neg", f_rsh(2'b10), 32'h8000_0000, 32'h1, 1'b0, 32'hC000_0000, 1'b0, 3'd2);
        vec("R8 LSR carry", f_rsh(2'b01), 32'h3, 32'hFFFF_FF01, 1'b0, 32'h1, 1'b1, 3'd1);
        vec("R9 amt0 hi", f_rsh(2'b00), 32'hABCD, 32'h100, 1'b1, 32'hABCD, 1'b1, 3'd0);
        vec("R9 LSL32", f_rsh(2'b00), 32'h1, 32'd32, 1'b0, 32'h0, 1'b1, 3'd0);
        vec("R9 LSR32", f_rsh(2'b01), 32'h8000_0000, 32'd32, 1'b0, 32'h0, 1'b1, 3'd1);
        vec("R9 LSL33", f_rsh(2'b00), 32'hFFFF_FFFF, 32'd33, 1'b1, 32'h0, 1'b0, 3'd0);
        vec("R9 LSR200", f_rsh(2'b01), 32'hFFFF_FFFF, 32'd200, 1'b1, 32'h0, 1'b0, 3'd1);
        vec("R9 ASR40", f_rsh(2'b10), 32'h8000_0000, 32'd40, 1'b0, 32'hFFFF_FFFF, 1'b1, 3'd2);
        vec("R9 ASR255", f_rsh(2'b10), 32'h4000_0000, 32'd255, 1'b1, 32'h0, 1'b0, 3'd2);
        vec("R10 ROR32", f_rsh(2'b11), 32'h8000_0001, 32'd32, 1'b0, 32'h8000_0001, 1'b1, 3'd3);
        vec("R10 ROR33", f_rsh(2'b11), 32'h3, 32'd33, 1'b0, 32'h8000_0001, 1'b1, 3'd3);
        vec("R10 ROR4", f_rsh(2'b11), 32'hF, 32'd4, 1'b0, 32'hF000_0000, 1'b1, 3'd3);
    endtask

    task automatic t_hold;
        vec("R1 load", f_imm(4'h0, 8'h5A), 32'h0, 32'h0, 1'b1, 32'h5A, 1'b1, 3'd5);
        @(negedge clk);
        instr = f_ish(5'd0, 2'b11); rm_val = 32'hFFFF_FFFF; carry_in = 1'b0;
        @(negedge clk);
        chk("R1 hold operand", operand, 32'h5A);
        chk("R1 hold carry", 32'(carry_out), 32'h1);
        chk("R1 hold kind", 32'(shift_kind), 32'd5);
        chk("R1 hold valid", 32'(out_valid), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_rot_imm();
        t_imm_shift();
        t_rrx();
        t_reg_shift();
        t_hold();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule